// File: doc/BRIEF.md
# Speculative Load Value Slot File

This block is a small storage array that sits beside the rename stage of an out-of-order core. It is indexed by a slot number that a dependence predictor has linked to a store-load pairing, never by a memory address. A renamed load reads its slot early and gets one of three answers. The slot may be empty. It may hold the value that the last retiring store left there. Or it may report that a producing store is still in flight, in which case the load receives that store's queue tag and waits.

Stores mark their slot as busy at rename time with their queue tag, and they deposit data only when they retire. Fresh slots are handed out to new pairings by least-recently-used replacement. Allocations, load reads and store retirements all count as uses.

The slot contents are never kept coherent with memory. Instead, a verify unit compares each renamed load's speculative value with the value the memory system later returns, and it flags a misspeculation when the two differ. The recovery that follows is handled elsewhere.

Top module: `rvf_slot_file`

## Requirements
- R1: While reset is held and on the first cycle after it, `rd_valid` and `chk_done` are low, every slot is empty, and the offered allocation slot is slot 0.
- R2: A read of a slot that has had no store retire or rename into it since its allocation returns kind EMPTY, encoded as `rd_kind` = 2'b00.
- R3: A read of a slot whose latest renamed store has not yet retired returns kind WAIT (`rd_kind` = 2'b10) with `rd_tag` equal to that store's queue tag. Store rename never changes the stored value, even when the slot already holds data.
- R4: A retiring store writes its data into its slot. If its tag equals the slot's in-flight tag, it also clears the in-flight state, and later reads return kind DATA (`rd_kind` = 2'b01) with that value on `rd_data`.
- R5: A retiring store whose tag differs from the slot's in-flight tag (a younger store has renamed since) still stores its data, but the slot stays busy, so reads keep returning WAIT with the younger tag.
- R6: When a retire and a read target the same slot in the same cycle, the read result already reflects that retire, following the same rules as R4 and R5.
- R7: `alloc_slot` always offers the least recently used slot, with ties going to the lowest index. Allocation, a load read and a store retire each make their slot the most recent. An allocation empties the slot it takes.
- R8: One cycle after `chk_valid`, `chk_done` is high and `chk_mispredict` is 1 exactly when `chk_pred` differs from `chk_mem`.
- R9: `rd_valid` is high exactly one cycle after `ld_valid`, and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Take the offered slot for a new pairing |
| alloc_slot | output | SW | Least recently used slot on offer |
| sren_valid | input | 1 | A store is renamed into a slot |
| sren_slot | input | SW | Slot of the renamed store |
| sren_tag | input | TAG_W | Queue tag of the renamed store |
| ret_valid | input | 1 | A store retires into a slot |
| ret_slot | input | SW | Slot of the retiring store |
| ret_tag | input | TAG_W | Queue tag of the retiring store |
| ret_data | input | DATA_W | Data of the retiring store |
| ld_valid | input | 1 | A renamed load reads a slot |
| ld_slot | input | SW | Slot the load reads |
| rd_valid | output | 1 | Read result valid |
| rd_kind | output | 2 | 00 empty, 01 data, 10 wait |
| rd_data | output | DATA_W | Slot value when kind is data |
| rd_tag | output | TAG_W | Producer tag when kind is wait |
| chk_valid | input | 1 | Verify a renamed load's value |
| chk_pred | input | DATA_W | Speculative value the load used |
| chk_mem | input | DATA_W | Value returned by memory |
| chk_done | output | 1 | Verify result valid |
| chk_mispredict | output | 1 | Speculative value was wrong |

## Verification
Damage to a slot's busy flag or tag shows on the very next read of that slot: a load that should wait gets DATA or the wrong tag, or a load that should proceed gets WAIT. Damage to a slot's value shows as a wrong `rd_data` one cycle after the read. Corrupted recency shows on `alloc_slot` in the cycle right after the touch that should have moved it, so the bench checks the offered slot after every allocation, read and retire in a full fill-and-touch sequence. The retire-with-stale-tag case and the same-cycle bypass are driven directly, because they are the points where a wrong busy update hides until a later read.

// File: rtl/rvf_pkg.sv
package rvf_pkg;

    typedef enum logic [1:0] {
        KIND_EMPTY = 2'b00,
        KIND_DATA  = 2'b01,
        KIND_WAIT  = 2'b10
    } slot_kind_e;

    // recency stamps handed out per cycle: alloc, retire, read
    localparam int TOUCH_STEP = 3;

    function automatic slot_kind_e classify(input logic has_value, input logic busy);
        if (busy)
            return KIND_WAIT;
        else if (has_value)
            return KIND_DATA;
        else
            return KIND_EMPTY;
    endfunction

endpackage

// File: rtl/rvf_lru.sv
module rvf_lru #(
    parameter int SLOTS   = 512,
    parameter int STAMP_W = 24,
    localparam int SW     = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_hit,
    input  logic [SW-1:0] alloc_idx,
    input  logic          wr_hit,
    input  logic [SW-1:0] wr_idx,
    input  logic          rd_hit,
    input  logic [SW-1:0] rd_idx,
    output logic [SW-1:0] victim
);
    import rvf_pkg::*;

    logic [STAMP_W-1:0] stamp [SLOTS];
    logic [STAMP_W-1:0] now;

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= STAMP_W'(1);
            for (int i = 0; i < SLOTS; i++)
                stamp[i] <= '0;
        end else begin
            if (alloc_hit || wr_hit || rd_hit)
                now <= now + STAMP_W'(TOUCH_STEP);
            if (alloc_hit)
                stamp[alloc_idx] <= now;
            if (wr_hit)
                stamp[wr_idx] <= now + STAMP_W'(1);
            if (rd_hit)
                stamp[rd_idx] <= now + STAMP_W'(2);
        end
    end

    logic [SW-1:0]      best;
    logic [STAMP_W-1:0] best_stamp;

    always_comb begin
        best       = '0;
        best_stamp = stamp[0];
        for (int i = 1; i < SLOTS; i++) begin
            if (stamp[i] < best_stamp) begin
                best       = SW'(i);
                best_stamp = stamp[i];
            end
        end
        victim = best;
    end

endmodule

// File: rtl/rvf_verify.sv
module rvf_verify #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [DATA_W-1:0] pred,
    input  logic [DATA_W-1:0] mem,
    output logic              done,
    output logic              wrong
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            wrong <= 1'b0;
        end else begin
            done  <= req;
            wrong <= req && (pred != mem);
        end
    end
endmodule

// File: rtl/rvf_slot_file.sv
module rvf_slot_file #(
    parameter int SLOTS   = 512,
    parameter int TAG_W   = 7,
    parameter int DATA_W  = 32,
    parameter int STAMP_W = 24,
    localparam int SW     = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    output logic [SW-1:0]     alloc_slot,
    input  logic              sren_valid,
    input  logic [SW-1:0]     sren_slot,
    input  logic [TAG_W-1:0]  sren_tag,
    input  logic              ret_valid,
    input  logic [SW-1:0]     ret_slot,
    input  logic [TAG_W-1:0]  ret_tag,
    input  logic [DATA_W-1:0] ret_data,
    input  logic              ld_valid,
    input  logic [SW-1:0]     ld_slot,
    output logic              rd_valid,
    output logic [1:0]        rd_kind,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag,
    input  logic              chk_valid,
    input  logic [DATA_W-1:0] chk_pred,
    input  logic [DATA_W-1:0] chk_mem,
    output logic              chk_done,
    output logic              chk_mispredict
);
    import rvf_pkg::*;

    typedef struct packed {
        logic              has_value;
        logic              busy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } slot_t;

    slot_t table_q [SLOTS];
    slot_t view;

    // slot state as seen by the reader, with this cycle's retire folded in
    always_comb begin
        view = table_q[ld_slot];
        if (ret_valid && ret_slot == ld_slot) begin
            view.has_value = 1'b1;
            view.value     = ret_data;
            if (view.busy && view.tag == ret_tag)
                view.busy = 1'b0;
        end
    end

    // slot updates: allocation clears, retire deposits, rename marks busy
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++)
                table_q[i] <= '0;
        end else begin
            if (alloc_req)
                table_q[alloc_slot] <= '0;
            if (ret_valid) begin
                table_q[ret_slot].has_value <= 1'b1;
                table_q[ret_slot].value     <= ret_data;
                if (table_q[ret_slot].busy && table_q[ret_slot].tag == ret_tag)
                    table_q[ret_slot].busy <= 1'b0;
            end
            if (sren_valid) begin
                table_q[sren_slot].busy <= 1'b1;
                table_q[sren_slot].tag  <= sren_tag;
            end
        end
    end

    slot_kind_e          kind_q;
    logic                rd_valid_q;
    logic [DATA_W-1:0]   rd_data_q;
    logic [TAG_W-1:0]    rd_tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            kind_q     <= KIND_EMPTY;
            rd_data_q  <= '0;
            rd_tag_q   <= '0;
        end else begin
            rd_valid_q <= ld_valid;
            if (ld_valid) begin
                kind_q    <= classify(view.has_value, view.busy);
                rd_data_q <= view.value;
                rd_tag_q  <= view.tag;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_kind  = kind_q;
    assign rd_data  = rd_data_q;
    assign rd_tag   = rd_tag_q;

    rvf_lru #(.SLOTS(SLOTS), .STAMP_W(STAMP_W)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .alloc_hit (alloc_req),
        .alloc_idx (alloc_slot),
        .wr_hit    (ret_valid),
        .wr_idx    (ret_slot),
        .rd_hit    (ld_valid),
        .rd_idx    (ld_slot),
        .victim    (alloc_slot)
    );

    rvf_verify #(.DATA_W(DATA_W)) u_verify (
        .clk   (clk),
        .rst   (rst),
        .req   (chk_valid),
        .pred  (chk_pred),
        .mem   (chk_mem),
        .done  (chk_done),
        .wrong (chk_mispredict)
    );

endmodule

// File: rtl/rvf_slot_file_chk.sv
module rvf_slot_file_chk #(
    parameter int SLOTS   = 512,
    parameter int TAG_W   = 7,
    parameter int DATA_W  = 32,
    localparam int SW     = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_req,
    input logic [SW-1:0]     alloc_slot,
    input logic              ret_valid,
    input logic [SW-1:0]     ret_slot,
    input logic [DATA_W-1:0] ret_data,
    input logic              ld_valid,
    input logic [SW-1:0]     ld_slot,
    input logic              rd_valid,
    input logic [1:0]        rd_kind,
    input logic [DATA_W-1:0] rd_data,
    input logic              chk_valid,
    input logic [DATA_W-1:0] chk_pred,
    input logic [DATA_W-1:0] chk_mem,
    input logic              chk_done,
    input logic              chk_mispredict
);
    assert_rd_latency_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rd_valid == $past(ld_valid));

    assert_kind_legal_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_kind != 2'b11);

    assert_verdict_timing_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> chk_done == $past(chk_valid));

    assert_mismatch_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(chk_valid)) |-> chk_mispredict == ($past(chk_pred) != $past(chk_mem)));

    assert_retire_bypass_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ld_valid && ret_valid && ld_slot == ret_slot))
            |-> rd_data == $past(ret_data));

    assert_alloc_moves_R7: assert property (@(posedge clk) disable iff (rst)
        (SLOTS > 1 && !$past(rst) && $past(alloc_req) && !$past(ld_valid) && !$past(ret_valid))
            |-> alloc_slot != $past(alloc_slot));
endmodule

bind rvf_slot_file rvf_slot_file_chk #(
    .SLOTS(SLOTS), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_slot(alloc_slot),
    .ret_valid(ret_valid), .ret_slot(ret_slot), .ret_data(ret_data),
    .ld_valid(ld_valid), .ld_slot(ld_slot),
    .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_data(rd_data),
    .chk_valid(chk_valid), .chk_pred(chk_pred), .chk_mem(chk_mem),
    .chk_done(chk_done), .chk_mispredict(chk_mispredict)
);

// File: tb/rvf_slot_file_test.sv
`timescale 1ns/1ps
module rvf_slot_file_test;
    localparam int SLOTS  = 8;
    localparam int TAG_W  = 6;
    localparam int DATA_W = 32;
    localparam int SW     = $clog2(SLOTS);

    localparam logic [1:0] K_EMPTY = 2'b00;
    localparam logic [1:0] K_DATA  = 2'b01;
    localparam logic [1:0] K_WAIT  = 2'b10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alloc_req = 1'b0;
    logic [SW-1:0]     alloc_slot;
    logic              sren_valid = 1'b0;
    logic [SW-1:0]     sren_slot = '0;
    logic [TAG_W-1:0]  sren_tag = '0;
    logic              ret_valid = 1'b0;
    logic [SW-1:0]     ret_slot = '0;
    logic [TAG_W-1:0]  ret_tag = '0;
    logic [DATA_W-1:0] ret_data = '0;
    logic              ld_valid = 1'b0;
    logic [SW-1:0]     ld_slot = '0;
    logic              rd_valid;
    logic [1:0]        rd_kind;
    logic [DATA_W-1:0] rd_data;
    logic [TAG_W-1:0]  rd_tag;
    logic              chk_valid = 1'b0;
    logic [DATA_W-1:0] chk_pred = '0;
    logic [DATA_W-1:0] chk_mem = '0;
    logic              chk_done;
    logic              chk_mispredict;

    always #10 clk = ~clk;

    rvf_slot_file #(.SLOTS(SLOTS), .TAG_W(TAG_W), .DATA_W(DATA_W)) uut (.*);

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0]        kind;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
        string             req;
    } rd_exp_t;

    typedef struct {
        logic  wrong;
        string req;
    } chk_exp_t;

    rd_exp_t  rdq[$];
    chk_exp_t ckq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // advance one cycle and drop all strobes
    task automatic step();
        @(posedge clk);
        #1;
        alloc_req  = 1'b0;
        sren_valid = 1'b0;
        ret_valid  = 1'b0;
        ld_valid   = 1'b0;
        chk_valid  = 1'b0;
    endtask

    task automatic do_read(input int slot, input logic [1:0] kind,
                           input logic [DATA_W-1:0] data, input logic [TAG_W-1:0] tag,
                           input string req);
        rd_exp_t e;
        ld_valid = 1'b1;
        ld_slot  = SW'(slot);
        e.kind = kind; e.data = data; e.tag = tag; e.req = req;
        rdq.push_back(e);
    endtask

    task automatic do_retire(input int slot, input logic [TAG_W-1:0] tag,
                             input logic [DATA_W-1:0] data);
        ret_valid = 1'b1;
        ret_slot  = SW'(slot);
        ret_tag   = tag;
        ret_data  = data;
    endtask

    task automatic do_rename(input int slot, input logic [TAG_W-1:0] tag);
        sren_valid = 1'b1;
        sren_slot  = SW'(slot);
        sren_tag   = tag;
    endtask

    task automatic do_check(input logic [DATA_W-1:0] p, input logic [DATA_W-1:0] m,
                            input string req);
        chk_exp_t e;
        chk_valid = 1'b1;
        chk_pred  = p;
        chk_mem   = m;
        e.wrong = (p != m);
        e.req   = req;
        ckq.push_back(e);
    endtask

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (rd_valid) begin
                if (rdq.size() == 0) begin
                    check(1'b0, "R9", "unexpected rd_valid", 64'(rd_valid), 64'd0);
                end else begin
                    rd_exp_t e;
                    e = rdq.pop_front();
                    check(rd_kind == e.kind, e.req, "rd_kind", 64'(rd_kind), 64'(e.kind));
                    if (e.kind == K_DATA)
                        check(rd_data == e.data, e.req, "rd_data", 64'(rd_data), 64'(e.data));
                    if (e.kind == K_WAIT)
                        check(rd_tag == e.tag, e.req, "rd_tag", 64'(rd_tag), 64'(e.tag));
                end
            end
            if (chk_done) begin
                if (ckq.size() == 0) begin
                    check(1'b0, "R8", "unexpected chk_done", 64'(chk_done), 64'd0);
                end else begin
                    chk_exp_t c;
                    c = ckq.pop_front();
                    check(chk_mispredict == c.wrong, c.req, "chk_mispredict",
                          64'(chk_mispredict), 64'(c.wrong));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_valid == 1'b0, "R1", "rd_valid in reset", 64'(rd_valid), 64'd0);
        check(chk_done == 1'b0, "R1", "chk_done in reset", 64'(chk_done), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", 64'(rd_valid), 64'd0);
        check(alloc_slot == '0, "R1", "alloc_slot after reset", 64'(alloc_slot), 64'd0);

        // R7: fill every slot in LRU order
        for (int i = 0; i < SLOTS; i++) begin
            step();
            check(alloc_slot == SW'(i), "R7", "fill order", 64'(alloc_slot), 64'(i));
            alloc_req = 1'b1;
        end
        step();
        check(alloc_slot == '0, "R7", "wrap to oldest", 64'(alloc_slot), 64'd0);

        // R2 on fresh slot; the read also refreshes slot 0
        do_read(0, K_EMPTY, '0, '0, "R2");
        step();
        check(alloc_slot == SW'(1), "R7", "read refreshes", 64'(alloc_slot), 64'd1);

        do_retire(1, 6'd0, 32'h1111_0001);
        step();
        check(alloc_slot == SW'(2), "R7", "retire refreshes", 64'(alloc_slot), 64'd2);
        alloc_req = 1'b1;
        step();
        check(alloc_slot == SW'(3), "R7", "alloc refreshes", 64'(alloc_slot), 64'd3);

        do_read(1, K_DATA, 32'h1111_0001, '0, "R4");
        step();

        // R3 / R4: in-flight store then retire
        do_rename(3, 6'd5);
        step();
        do_read(3, K_WAIT, '0, 6'd5, "R3");
        step();
        do_retire(3, 6'd5, 32'hA5A5_0003);
        step();
        do_read(3, K_DATA, 32'hA5A5_0003, '0, "R4");
        step();

        // R3: rename on a slot holding data gives wait, value untouched
        do_rename(3, 6'd2);
        step();
        do_read(3, K_WAIT, '0, 6'd2, "R3");
        step();
        do_retire(3, 6'd2, 32'hA5A5_0033);
        step();
        do_read(3, K_DATA, 32'hA5A5_0033, '0, "R3");
        step();

        // R6: same-cycle retire and read, idle slot and busy slot
        do_retire(4, 6'd0, 32'hBBBB_0004);
        do_read(4, K_DATA, 32'hBBBB_0004, '0, "R6");
        step();
        do_rename(5, 6'd12);
        step();
        do_retire(5, 6'd12, 32'hCCCC_0005);
        do_read(5, K_DATA, 32'hCCCC_0005, '0, "R6");
        step();

        // R5: older store retires after younger rename
        do_rename(6, 6'd7);
        step();
        do_rename(6, 6'd9);
        step();
        do_retire(6, 6'd7, 32'hDDDD_0006);
        step();
        do_read(6, K_WAIT, '0, 6'd9, "R5");
        step();
        do_retire(6, 6'd9, 32'hEEEE_0006);
        do_read(6, K_DATA, 32'hEEEE_0006, '0, "R6");
        step();
        do_read(6, K_DATA, 32'hEEEE_0006, '0, "R4");
        step();

        // R8: verify unit, match and mismatch back to back
        do_check(32'h1234_5678, 32'h1234_5678, "R8");
        step();
        do_check(32'h1234_5678, 32'h1234_5679, "R8");
        step();
        do_check(32'h0, 32'h8000_0000, "R8");
        step();
        step();
        step();

        check(rdq.size() == 0, "R9", "reads outstanding", 64'(rdq.size()), 64'd0);
        check(ckq.size() == 0, "R8", "checks outstanding", 64'(ckq.size()), 64'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule